// File: doc/BRIEF.md
# Capture and Reload Timer

This block is a parameterised up/down timer and event counter. A small register interface controls it. It has four operating modes:

- **Capture.** The trigger pin latches the live count.
- **Auto-reload up-only.** The count is refilled from a reload register on overflow, or on a trigger edge.
- **Auto-reload up/down.** The level on the trigger pin picks the counting direction.
- **Baud.** Each overflow refills the count and emits a single-cycle tick for a serial clock divider.

The counter advances on one of two sources. The first is an internal machine-cycle tick, which is the system clock divided by `PRESCALE`. The second is a falling edge on an external count pin, sampled once per machine cycle.

Software writes a control register, the count, and the shared capture/reload register. It reads them back, together with a direction-indicator bit, through a combinational read port. An overflow flag and an external-event flag stay set until software clears them. Both flags are also driven out as pins so that an interrupt controller can use them.

Top module: `captureReloadTimer`

## Requirements
- R1: After reset the control register, the count, the capture/reload register, the direction bit, both flags and the baud tick are all 0.
- R2: In counter operation (run=1, source=1), each falling edge of the count pin advances the count by exactly one. Each pin level must be held for at least two machine cycles. While run=0 the count does not change.
- R3: In capture mode, a step from the all-ones count wraps to 0 and sets the overflow flag.
- R4: In capture mode with external enable set, a trigger-pin falling edge copies the count into the capture/reload register and sets the external-event flag. With external enable clear, a trigger edge changes neither.
- R5: In up-only reload mode, a step from all-ones loads the reload value and sets the overflow flag.
- R6: In up-only reload mode with external enable set, a trigger-pin falling edge loads the reload value into the count and sets the external-event flag.
- R7: In up/down mode, trigger pin high counts up and trigger pin low counts down. Trigger edges never set the external-event flag in this mode.
- R8: In up/down mode counting down, a step taken while the count equals the reload value loads all-ones and sets the overflow flag. Every overflow in this mode, in either direction, toggles the direction bit.
- R9: In baud mode, a step from all-ones loads the reload value and produces a `baudTick` pulse exactly one cycle wide. The overflow flag is not set.
- R10: In baud mode with external enable set, a trigger-pin falling edge sets the external-event flag. It leaves both the count and the capture/reload register unchanged.
- R11: The flags are sticky. Writing the control register with bit 6 (overflow) or bit 7 (event) at 0 clears that flag. Writing 1 leaves the flag as it is and never sets it.
- R12: In timer operation (source=0), the count advances once every `PRESCALE` clocks while run=1.
- R13: Register map:
  - Address 0 is control. Its bits are run 0, source 1, external enable 2, capture select 3, down enable 4, baud 5, overflow flag 6, event flag 7.
  - Address 1 is the count.
  - Address 2 is the capture/reload register.
  - Address 3 is status, with the direction bit at bit 0.
  - A write to the count or to the capture/reload register takes priority over hardware updates in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | CNT_W | Read data (combinational) |
| cntPin | input | 1 | External count input |
| trigPin | input | 1 | External trigger / direction input |
| baudTick | output | 1 | One-cycle pulse per baud-mode overflow |
| ovfFlag | output | 1 | Sticky overflow flag |
| extFlag | output | 1 | Sticky external-event flag |

## Verification
The bench builds the timer with `CNT_W = 8` and `PRESCALE = 2`. The 8-bit count lets every wrap, reload and underflow boundary be reached within a few hundred count-pin pulses. The bench therefore sweeps full rollovers in capture, up-only, up/down and baud modes and predicts every intermediate count arithmetically. A short prescaler keeps each pulse at eight clocks, so long sweeps fit well inside the run budget. Those sweeps cover reload values of 0, mid-range, near-top and all-ones.

// File: rtl/crt_pkg.sv
package crt_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CAP   = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  localparam int BIT_RUN   = 0;
  localparam int BIT_SRC   = 1;
  localparam int BIT_EXTEN = 2;
  localparam int BIT_CAPS  = 3;
  localparam int BIT_DOWN  = 4;
  localparam int BIT_BAUD  = 5;
  localparam int BIT_OVF   = 6;
  localparam int BIT_EVT   = 7;

  typedef struct packed {
    logic baud;
    logic downEn;
    logic capSel;
    logic extEn;
    logic ctSel;
    logic run;
  } ctrl_t;

  typedef enum logic [1:0] {
    MODE_CAPTURE,
    MODE_RELOAD,
    MODE_UPDN,
    MODE_BAUD
  } mode_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_DEC,
    OP_RELOAD,
    OP_MAX,
    OP_ZERO,
    OP_WRITE
  } cntOp_e;

  typedef struct packed {
    cntOp_e op;
    logic   capture;
    logic   capWrite;
    logic   dirToggle;
  } strobe_t;

  typedef struct packed {
    logic atMax;
    logic atReload;
  } dpStat_t;

endpackage

// File: rtl/crtTickGen.sv
module crtTickGen #(
  parameter int PRESCALE    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cntPin,
  input  logic trigPin,
  output logic mcTick,
  output logic cntFall,
  output logic trigFall,
  output logic trigLevel
);

  localparam int PW    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int NPINS = 2;

  logic [PW-1:0]    div;
  logic [NPINS-1:0] syncStage [SYNC_STAGES];
  logic [NPINS-1:0] pinSync;
  logic [NPINS-1:0] lastSamp;
  logic [NPINS-1:0] fall;

  assign mcTick = (div == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rstN)       div <= '0;
    else if (mcTick) div <= '0;
    else             div <= div + 1'b1;
  end

  // Synchronizer chain for both asynchronous pins.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[0] <= '0;
        else       syncStage[0] <= {trigPin, cntPin};
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[s] <= '0;
        else       syncStage[s] <= syncStage[s-1];
      end
    end
  end

  assign pinSync = syncStage[SYNC_STAGES-1];

  // One sample per machine cycle; a fall is a high sample followed by a low one.
  always_ff @(posedge clk) begin
    if (!rstN)       lastSamp <= '0;
    else if (mcTick) lastSamp <= pinSync;
  end

  assign fall      = {NPINS{mcTick}} & lastSamp & ~pinSync;
  assign cntFall   = fall[0];
  assign trigFall  = fall[1];
  assign trigLevel = pinSync[1];

endmodule

// File: rtl/crtControl.sv
module crtControl
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             mcTick,
  input  logic             cntFall,
  input  logic             trigFall,
  input  logic             trigLevel,
  input  dpStat_t          stat,
  output strobe_t          strobe,
  output ctrl_t            ctrl,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             baudTick
);

  mode_e mode;
  logic  ctrlWr, countWr, step, extEvt;
  logic  ovfSet, extSet, baudWrap;

  assign ctrlWr  = wrEn && (wrAddr == ADDR_CTRL);
  assign countWr = wrEn && (wrAddr == ADDR_COUNT);
  assign step    = mcTick && ctrl.run && (ctrl.ctSel ? cntFall : 1'b1);
  assign extEvt  = trigFall && ctrl.extEn;

  always_comb begin
    if (ctrl.baud)        mode = MODE_BAUD;
    else if (ctrl.capSel) mode = MODE_CAPTURE;
    else if (ctrl.downEn) mode = MODE_UPDN;
    else                  mode = MODE_RELOAD;
  end

  always_comb begin
    strobe.op        = OP_HOLD;
    strobe.capture   = 1'b0;
    strobe.dirToggle = 1'b0;
    strobe.capWrite  = wrEn && (wrAddr == ADDR_CAP);
    ovfSet           = 1'b0;
    extSet           = 1'b0;
    baudWrap         = 1'b0;
    unique case (mode)
      MODE_CAPTURE: begin
        strobe.capture = extEvt;
        extSet         = extEvt;
        if (step) begin
          if (stat.atMax) begin
            strobe.op = OP_ZERO;
            ovfSet    = 1'b1;
          end else begin
            strobe.op = OP_INC;
          end
        end
      end
      MODE_RELOAD: begin
        extSet = extEvt;
        if (extEvt) begin
          strobe.op = OP_RELOAD;
        end else if (step) begin
          if (stat.atMax) begin
            strobe.op = OP_RELOAD;
            ovfSet    = 1'b1;
          end else begin
            strobe.op = OP_INC;
          end
        end
      end
      MODE_UPDN: begin
        if (step) begin
          if (trigLevel) begin
            if (stat.atMax) begin
              strobe.op        = OP_RELOAD;
              ovfSet           = 1'b1;
              strobe.dirToggle = 1'b1;
            end else begin
              strobe.op = OP_INC;
            end
          end else begin
            if (stat.atReload) begin
              strobe.op        = OP_MAX;
              ovfSet           = 1'b1;
              strobe.dirToggle = 1'b1;
            end else begin
              strobe.op = OP_DEC;
            end
          end
        end
      end
      default: begin
        extSet = extEvt;
        if (step) begin
          if (stat.atMax) begin
            strobe.op = OP_RELOAD;
            baudWrap  = 1'b1;
          end else begin
            strobe.op = OP_INC;
          end
        end
      end
    endcase
    // A software write to the count overrides any hardware step.
    if (countWr) begin
      strobe.op        = OP_WRITE;
      strobe.dirToggle = 1'b0;
      ovfSet           = 1'b0;
      baudWrap         = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl     <= '0;
      ovfFlag  <= 1'b0;
      extFlag  <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrl.run    <= wrData[BIT_RUN];
        ctrl.ctSel  <= wrData[BIT_SRC];
        ctrl.extEn  <= wrData[BIT_EXTEN];
        ctrl.capSel <= wrData[BIT_CAPS];
        ctrl.downEn <= wrData[BIT_DOWN];
        ctrl.baud   <= wrData[BIT_BAUD];
      end
      ovfFlag  <= ovfSet | (ovfFlag & ~(ctrlWr & ~wrData[BIT_OVF]));
      extFlag  <= extSet | (extFlag & ~(ctrlWr & ~wrData[BIT_EVT]));
      baudTick <= baudWrap;
    end
  end

endmodule

// File: rtl/crtDatapath.sv
module crtDatapath
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] capVal,
  output logic             dirBit,
  output dpStat_t          stat
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  assign stat.atMax    = (countVal == ALL_ONES);
  assign stat.atReload = (countVal == capVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else begin
      unique case (strobe.op)
        OP_INC:    countVal <= countVal + 1'b1;
        OP_DEC:    countVal <= countVal - 1'b1;
        OP_RELOAD: countVal <= capVal;
        OP_MAX:    countVal <= ALL_ONES;
        OP_ZERO:   countVal <= '0;
        OP_WRITE:  countVal <= wrData;
        default:   countVal <= countVal;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               capVal <= '0;
    else if (strobe.capWrite) capVal <= wrData;
    else if (strobe.capture)  capVal <= countVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dirBit <= 1'b0;
    else if (strobe.dirToggle) dirBit <= ~dirBit;
  end

endmodule

// File: rtl/captureReloadTimer.sv
module captureReloadTimer
  import crt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             cntPin,
  input  logic             trigPin,
  output logic             baudTick,
  output logic             ovfFlag,
  output logic             extFlag
);

  logic             mcTick, cntFall, trigFall, trigLevel;
  strobe_t          strobe;
  ctrl_t            ctrl;
  dpStat_t          stat;
  logic [CNT_W-1:0] countVal, capVal;
  logic             dirBit;

  crtTickGen #(.PRESCALE(PRESCALE), .SYNC_STAGES(2)) uTick (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .trigPin(trigPin),
    .mcTick(mcTick), .cntFall(cntFall), .trigFall(trigFall), .trigLevel(trigLevel)
  );

  crtControl #(.CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .mcTick(mcTick), .cntFall(cntFall), .trigFall(trigFall), .trigLevel(trigLevel),
    .stat(stat), .strobe(strobe), .ctrl(ctrl),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .baudTick(baudTick)
  );

  crtDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .countVal(countVal), .capVal(capVal), .dirBit(dirBit), .stat(stat)
  );

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_CTRL: begin
        rdData[BIT_RUN]   = ctrl.run;
        rdData[BIT_SRC]   = ctrl.ctSel;
        rdData[BIT_EXTEN] = ctrl.extEn;
        rdData[BIT_CAPS]  = ctrl.capSel;
        rdData[BIT_DOWN]  = ctrl.downEn;
        rdData[BIT_BAUD]  = ctrl.baud;
        rdData[BIT_OVF]   = ovfFlag;
        rdData[BIT_EVT]   = extFlag;
      end
      ADDR_COUNT: rdData = countVal;
      ADDR_CAP:   rdData = capVal;
      default:    rdData[0] = dirBit;
    endcase
  end

endmodule

// File: rtl/crtChecker.sv
module crtChecker
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             ctrlRun,
  input logic             ctrlExtEn,
  input logic             updnMode,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] capVal,
  input logic             dirBit,
  input logic             ovfFlag,
  input logic             extFlag,
  input logic             baudTick
);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRun && !ctrlExtEn && !(wrEn && wrAddr == ADDR_COUNT)) |=> $stable(countVal));

  p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlExtEn && !(wrEn && wrAddr == ADDR_CAP)) |=> $stable(capVal));

  p_no_evt_updn_r7: assert property (@(posedge clk) disable iff (!rstN)
    updnMode |=> !$rose(extFlag));

  p_dir_with_ovf_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dirBit) |-> ovfFlag);

  p_baud_no_ovf_r9: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> !$rose(ovfFlag));

  p_baud_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrEn && wrAddr == ADDR_CTRL && !wrData[BIT_OVF])) |=> ovfFlag);

  p_evt_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (extFlag && !(wrEn && wrAddr == ADDR_CTRL && !wrData[BIT_EVT])) |=> extFlag);

endmodule

bind captureReloadTimer crtChecker #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ctrlRun(ctrl.run), .ctrlExtEn(ctrl.extEn),
  .updnMode(!ctrl.baud && !ctrl.capSel && ctrl.downEn),
  .countVal(countVal), .capVal(capVal), .dirBit(dirBit),
  .ovfFlag(ovfFlag), .extFlag(extFlag), .baudTick(baudTick)
);

// File: tb/captureReloadTimer_test.sv
`timescale 1ns/1ps
module captureReloadTimer_test;

  localparam int CNT_W    = 8;
  localparam int PRESCALE = 2;
  localparam int MAXV     = (1 << CNT_W) - 1;

  localparam logic [7:0] C_RUN = 8'h01, C_SRC = 8'h02, C_EXT = 8'h04, C_CAP = 8'h08;
  localparam logic [7:0] C_DN  = 8'h10, C_BAUD = 8'h20, C_KEEPO = 8'h40, C_KEEPE = 8'h80;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [1:0]       rdAddr = '0;
  logic [CNT_W-1:0] rdData;
  logic             cntPin = 1'b0;
  logic             trigPin = 1'b1;
  logic             baudTick, ovfFlag, extFlag;

  int checks = 0;
  int fails = 0;
  int baudCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  captureReloadTimer #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cntPin(cntPin), .trigPin(trigPin),
    .baudTick(baudTick), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  always @(negedge clk) if (baudTick) baudCnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output int v);
    @(negedge clk);
    rdAddr = a;
    #1 v = int'(rdData);
  endtask

  task automatic pulse();
    cntPin = 1'b1;
    repeat (4) @(negedge clk);
    cntPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic trigEdge();
    trigPin = 1'b0;
    repeat (4) @(negedge clk);
    trigPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    int v, v2, exp, wraps, dirExp;
    int rel [4] = '{0, 128, 240, 255};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), v);
      check("R1 register", v, 0);
    end
    check("R1 ovfFlag", int'(ovfFlag), 0);
    check("R1 extFlag", int'(extFlag), 0);
    check("R1 baudTick", int'(baudTick), 0);

    // R13 register readback
    writeReg(2'd1, 8'h37); readReg(2'd1, v); check("R13 count write", v, 'h37);
    writeReg(2'd2, 8'hA5); readReg(2'd2, v); check("R13 cap write", v, 'hA5);
    writeReg(2'd0, C_SRC | C_CAP); readReg(2'd0, v); check("R13 ctrl write", v, C_SRC | C_CAP);

    // R2 / R3 counter sweep in capture mode
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, C_RUN | C_SRC | C_CAP);
    for (int n = 1; n <= 300; n++) begin
      pulse();
      readReg(2'd1, v);
      check("R2 count per edge", v, n % 256);
      check("R3 overflow flag", int'(ovfFlag), (n >= 256) ? 1 : 0);
    end
    writeReg(2'd0, C_SRC | C_CAP | C_KEEPO);
    repeat (3) pulse();
    readReg(2'd1, v);
    check("R2 stopped holds", v, 300 % 256);

    // R11 sticky flags
    check("R11 keep with bit=1", int'(ovfFlag), 1);
    writeReg(2'd0, C_SRC | C_CAP | C_KEEPE);
    check("R11 clear with bit=0", int'(ovfFlag), 0);
    writeReg(2'd0, C_SRC | C_CAP | C_KEEPO | C_KEEPE);
    check("R11 write 1 does not set", int'(ovfFlag), 0);

    // R4 capture without and with external enable
    writeReg(2'd1, 8'h33);
    writeReg(2'd2, 8'h00);
    trigEdge();
    readReg(2'd2, v);
    check("R4 no capture when disabled", v, 0);
    check("R4 no flag when disabled", int'(extFlag), 0);
    writeReg(2'd0, C_SRC | C_CAP | C_EXT);
    for (int c = 0; c < 256; c += 15) begin
      writeReg(2'd1, 8'(c));
      trigEdge();
      readReg(2'd2, v);
      check("R4 captured value", v, c);
      check("R4 event flag", int'(extFlag), 1);
      writeReg(2'd0, C_SRC | C_CAP | C_EXT | C_KEEPO);
      check("R11 event cleared", int'(extFlag), 0);
    end

    // R5 up-only reload sweep
    foreach (rel[i]) begin
      writeReg(2'd0, 8'h00);
      writeReg(2'd2, 8'(rel[i]));
      writeReg(2'd1, 8'(rel[i]));
      writeReg(2'd0, C_RUN | C_SRC);
      exp = rel[i]; wraps = 0;
      for (int k = 0; k < 2 * (256 - rel[i]) + 3; k++) begin
        pulse();
        if (exp == MAXV) begin exp = rel[i]; wraps++; end
        else exp++;
        readReg(2'd1, v);
        check("R5 reload count", v, exp);
        check("R5 overflow flag", int'(ovfFlag), (wraps > 0) ? 1 : 0);
      end
    end

    // R6 trigger-forced reload
    writeReg(2'd0, C_RUN | C_SRC | C_EXT);
    writeReg(2'd2, 8'h99);
    writeReg(2'd1, 8'h10);
    trigEdge();
    readReg(2'd1, v);
    check("R6 forced reload", v, 'h99);
    check("R6 event flag", int'(extFlag), 1);

    // R7 / R8 up/down mode
    writeReg(2'd0, 8'h00);
    writeReg(2'd2, 8'h40);
    writeReg(2'd1, 8'hFD);
    writeReg(2'd0, C_RUN | C_SRC | C_DN | C_EXT);
    exp = 'hFD; dirExp = 0;
    for (int k = 0; k < 5; k++) begin
      pulse();
      if (exp == MAXV) begin exp = 'h40; dirExp ^= 1; end
      else exp++;
      readReg(2'd1, v);
      check("R7 up count", v, exp);
    end
    readReg(2'd3, v);
    check("R8 dir after up overflow", v, dirExp);
    check("R8 overflow flag up", int'(ovfFlag), 1);
    trigPin = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 no event in updn", int'(extFlag), 0);
    writeReg(2'd1, 8'h43);
    exp = 'h43;
    for (int k = 0; k < 400; k++) begin
      pulse();
      if (exp == 'h40) begin exp = MAXV; dirExp ^= 1; end
      else exp--;
      readReg(2'd1, v);
      check("R7 down count", v, exp);
      readReg(2'd3, v2);
      check("R8 dir bit", v2, dirExp);
    end
    check("R8 overflow flag down", int'(ovfFlag), 1);
    check("R7 no event after down run", int'(extFlag), 0);
    trigPin = 1'b1;
    repeat (8) @(negedge clk);

    // R9 baud mode
    writeReg(2'd0, 8'h00);
    writeReg(2'd2, 8'hFA);
    writeReg(2'd1, 8'hFA);
    baudCnt = 0;
    writeReg(2'd0, C_RUN | C_SRC | C_BAUD);
    exp = 'hFA; wraps = 0;
    for (int k = 0; k < 40; k++) begin
      pulse();
      if (exp == MAXV) begin exp = 'hFA; wraps++; end
      else exp++;
      readReg(2'd1, v);
      check("R9 baud count", v, exp);
    end
    check("R9 tick cycles per overflow", baudCnt, wraps);
    check("R9 overflow flag untouched", int'(ovfFlag), 0);

    // R10 baud trigger is event only
    writeReg(2'd0, C_SRC | C_BAUD | C_EXT);
    writeReg(2'd1, 8'h77);
    trigEdge();
    check("R10 event flag", int'(extFlag), 1);
    readReg(2'd1, v);
    check("R10 count unchanged", v, 'h77);
    readReg(2'd2, v);
    check("R10 reload unchanged", v, 'hFA);

    // R12 timer mode
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, C_RUN);
    repeat (40) @(negedge clk);
    writeReg(2'd0, 8'h00);
    readReg(2'd1, v);
    check("R12 timer rate", (v >= 19 && v <= 22) ? 1 : 0, 1);
    if (!(v >= 19 && v <= 22)) $display("  R12 count was %0d", v);

    finishRun();
  end

endmodule